// File: doc/BRIEF.md
# LFSR Programmable Clock Divider

This block divides its clock by a programmable ratio. A binary adder does not count the cycles. A small linear feedback shift register does, so the next-state logic per bit is a single wire or one XNOR gate, and the terminal test is an equality compare against a programmed state. Two values set the ratio: a start state and a terminal state. The register runs from the start state until it matches the terminal state. On the next edge it reloads the start state. A one-cycle pulse marks each reload, and a companion output toggles on every reload to give a square wave at half the pulse rate.

The start and terminal states that give a wanted ratio are computed outside the block by stepping the same register. The divider captures both values at reset and at each reload. It ignores them at all other times, so software or a neighbouring block can change them at any moment, and the change lands cleanly on a period boundary.

Top module: `lfsr_clk_div`

## Requirements
- R1: While `rst` is high at a clock edge, the count register loads `start_state` and the terminal register loads `term_state`. `pulse_o` and `wave_o` are low in the following cycle.
- R2: In a non-terminal cycle the count register advances one step. Bit 0 takes the top bit. Every higher bit N takes bit N-1, XNORed with the top bit when bit N of `TAPS` is set. The default `TAPS` is 4'b0010, which is x^4+x+1 in XNOR form.
- R3: When the count register equals the captured terminal state, the next edge reloads `start_state` and `pulse_o` is high for exactly the cycle that follows.
- R4: `pulse_o` is low in every cycle that does not follow a terminal cycle.
- R5: The spacing between successive pulses equals the number of steps from start to terminal, plus one. With start 4'b0000 and terminal 4'b0101, `pulse_o` rises once every 13 clocks.
- R6: `wave_o` is low after reset and inverts on every reload edge. Its period is therefore twice the division ratio.
- R7: `start_state` and `term_state` are captured only at reset and at reload. A change made at any other time first takes effect in the period that begins at the next reload.
- R8: When start equals terminal, the ratio is 1 and `pulse_o` stays high on every cycle.
- R9: The all-ones state maps to itself. A start of 4'b1111 with any other terminal never produces a pulse, and only a reset leaves that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| start_state | input | WIDTH | State loaded at reset and at each reload |
| term_state | input | WIDTH | State whose match ends a period |
| pulse_o | output | 1 | One-cycle pulse per division period |
| wave_o | output | 1 | Square wave toggled once per period |

## Verification
A terminal match and a change of the programmed pair can fall in the same cycle. In that case the reload edge must capture the new pair, not the old one. The bench uses its model to locate the cycle in which the register holds the terminal state. It writes a new pair in exactly that cycle and then checks that the very next period already has the new spacing. It also checks the opposite case: a change made in the middle of a period must leave that period at its old length.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

    localparam int          DEF_WIDTH = 4;
    localparam logic [3:0]  DEF_TAPS  = 4'b0010;
    localparam logic [3:0]  DEF_START = 4'b0000;
    localparam logic [3:0]  DEF_TERM  = 4'b0101;

    // what the count register does on the coming edge
    typedef enum logic [1:0] {
        ACT_LOAD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_WRAP  = 2'd2
    } div_act_e;

    typedef struct packed {
        logic pulse;
        logic wave;
    } div_out_t;

    function automatic logic act_is_wrap(div_act_e a);
        return a == ACT_WRAP;
    endfunction

endpackage

// File: rtl/lfsr_div_step.sv
module lfsr_div_step #(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] TAPS  = 4'b0010
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    localparam int TOP = WIDTH - 1;

    assign nxt[0] = cur[TOP];

    for (genvar n = 1; n < WIDTH; n++) begin : g_bit
        if (TAPS[n]) begin : g_tap
            assign nxt[n] = cur[n-1] ~^ cur[TOP];
        end else begin : g_wire
            assign nxt[n] = cur[n-1];
        end
    end
endmodule

// File: rtl/lfsr_div_count.sv
module lfsr_div_count
    import lfsr_div_pkg::*;
#(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] TAPS  = 4'b0010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] start_state,
    input  logic [WIDTH-1:0] term_state,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] term_q,
    output div_act_e         act
);
    logic [WIDTH-1:0] cnt_step;

    lfsr_div_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
        .cur (cnt_q),
        .nxt (cnt_step)
    );

    always_comb begin
        if (rst)                 act = ACT_LOAD;
        else if (cnt_q == term_q) act = ACT_WRAP;
        else                     act = ACT_SHIFT;
    end

    always_ff @(posedge clk) begin
        case (act)
            ACT_LOAD, ACT_WRAP: begin
                cnt_q  <= start_state;
                term_q <= term_state;
            end
            default: begin
                cnt_q  <= cnt_step;
            end
        endcase
    end

    property p_reload_start;
        @(posedge clk) disable iff (rst)
        (cnt_q == term_q) |=> (cnt_q == $past(start_state));
    endproperty
    AST_RELOAD_START: assert property (p_reload_start); // R3

    property p_term_held;
        @(posedge clk) disable iff (rst)
        (cnt_q != term_q) |=> $stable(term_q);
    endproperty
    AST_TERM_HELD: assert property (p_term_held); // R7

    property p_lockup;
        @(posedge clk) disable iff (rst)
        ((&cnt_q) && (cnt_q != term_q)) |=> (&cnt_q);
    endproperty
    AST_LOCKUP_STAYS: assert property (p_lockup); // R9

endmodule

// File: rtl/lfsr_div_tick.sv
module lfsr_div_tick
    import lfsr_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_act_e act,
    output div_out_t outs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            outs <= '0;
        end else begin
            outs.pulse <= act_is_wrap(act);
            if (act_is_wrap(act)) outs.wave <= ~outs.wave;
        end
    end

    property p_wave_flip;
        @(posedge clk) disable iff (rst)
        outs.pulse |-> (outs.wave != $past(outs.wave));
    endproperty
    AST_WAVE_FLIP: assert property (p_wave_flip); // R6

    property p_wave_hold;
        @(posedge clk) disable iff (rst)
        !outs.pulse |-> $stable(outs.wave);
    endproperty
    AST_WAVE_HOLD: assert property (p_wave_hold); // R6

endmodule

// File: rtl/lfsr_clk_div.sv
module lfsr_clk_div
    import lfsr_div_pkg::*;
#(
    parameter int               WIDTH = DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAPS  = DEF_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] start_state,
    input  logic [WIDTH-1:0] term_state,
    output logic             pulse_o,
    output logic             wave_o
);
    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] term_q;
    div_act_e         act;
    div_out_t         outs;

    lfsr_div_count #(.WIDTH(WIDTH), .TAPS(TAPS)) u_count (
        .clk         (clk),
        .rst         (rst),
        .start_state (start_state),
        .term_state  (term_state),
        .cnt_q       (cnt),
        .term_q      (term_q),
        .act         (act)
    );

    lfsr_div_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .act  (act),
        .outs (outs)
    );

    assign pulse_o = outs.pulse;
    assign wave_o  = outs.wave;

    property p_pulse_on_match;
        @(posedge clk) disable iff (rst)
        (cnt == term_q) |=> pulse_o;
    endproperty
    AST_PULSE_ON_MATCH: assert property (p_pulse_on_match); // R3

    property p_quiet;
        @(posedge clk) disable iff (rst)
        (cnt != term_q) |=> !pulse_o;
    endproperty
    AST_QUIET_OTHERWISE: assert property (p_quiet); // R4

    property p_reset_clear;
        @(posedge clk)
        rst |=> (!pulse_o && !wave_o && cnt == $past(start_state));
    endproperty
    AST_RESET_CLEAR: assert property (p_reset_clear); // R1

endmodule

// File: tb/lfsr_clk_div_bench.sv
module lfsr_clk_div_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] start_s = 4'b0000;
    logic [3:0] term_s  = 4'b0101;
    logic       pulse, wave;

    int total = 0, bad = 0, cyc = 0;
    int m_cnt = 0, m_term = 0, m_pulse = 0, m_wave = 0, per_ratio = 0;
    int exp_space = 0, last_pulse = -1, pulse_cnt = 0;
    bit finished = 0;
    string tag = "R5 default";

    lfsr_clk_div u_lfsr_clk_div (
        .clk (clk), .rst (rst), .start_state (start_s),
        .term_state (term_s), .pulse_o (pulse), .wave_o (wave)
    );

    always #10 clk = ~clk;   // 50 MHz

    // one step of x^4+x+1 in XNOR form, written as shift plus mask
    function automatic int adv(int m);
        int fb = (m >> 3) & 1;
        int n  = ((m << 1) & 15) | fb;
        if (fb == 0) n = n ^ 2;
        return n;
    endfunction

    function automatic int ratio_of(int s, int t);
        int x = s;
        for (int i = 1; i <= 16; i++) begin
            if (x == t) return i;
            x = adv(x);
        end
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // behavioural reference
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_cnt <= start_s; m_term <= term_s; m_pulse <= 0; m_wave <= 0;
            per_ratio <= ratio_of(start_s, term_s);
        end else if (m_cnt == m_term) begin
            m_cnt <= start_s; m_term <= term_s; m_pulse <= 1; m_wave <= 1 - m_wave;
            per_ratio <= ratio_of(start_s, term_s);
        end else begin
            m_cnt <= adv(m_cnt); m_pulse <= 0;
        end
    end

    // compare every cycle, away from the edge
    always @(negedge clk) begin
        if (cyc > 0 && !finished) begin
            chk(m_pulse ? "R3 pulse" : (cyc < 6 ? "R1 reset" : "R4 quiet"), int'(pulse), m_pulse);
            chk("R6 wave", int'(wave), m_wave);
            if (rst) begin
                last_pulse = -1;
            end else if (pulse) begin
                pulse_cnt++;
                if (last_pulse >= 0) chk({tag, " spacing"}, cyc - last_pulse, exp_space);
                last_pulse = cyc;
                exp_space  = per_ratio;
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_terminal();
        while (m_cnt != m_term) @(negedge clk);
    endtask

    initial begin
        run(4);
        chk("R1 reset pulse", int'(pulse), 0);
        chk("R1 reset wave", int'(wave), 0);
        rst = 1'b0;
        // default pair: first pulse 13 clocks after release
        run(13);
        chk("R5 first pulse at 13", int'(pulse), 1);
        run(1);
        chk("R4 low after pulse", int'(pulse), 0);
        run(13 * 5);
        chk("R5 divide by 13", ratio_of(0, 5), 13);

        // change mid-period: current period keeps 13, next becomes 4
        tag = "R7 midchange";
        run(5);
        start_s = 4'b0110; term_s = 4'b1011;
        run(40);

        // R2: other pairs exercise the step rule across the wrap of the sequence
        tag = "R2 wrap";
        start_s = 4'b1001; term_s = 4'b1110;
        run(60);

        // change in the terminal cycle itself: takes effect at once
        tag = "R7 same cycle";
        wait_terminal();
        start_s = 4'b0000; term_s = 4'b0001;
        run(1);
        chk("R7 same-cycle reload", int'(pulse), 1);
        run(15);
        chk("R5 maximal 15", int'(pulse), 1);
        run(45);

        // equal pair: continuous pulse
        tag = "R8 equal";
        start_s = 4'b0011; term_s = 4'b0011;
        wait_terminal();
        run(3);
        chk("R8 pulse held high", int'(pulse), 1);
        run(10);
        chk("R8 pulse held high later", int'(pulse), 1);

        // lockup state
        tag = "R9 lockup";
        start_s = 4'b1111; term_s = 4'b0000;
        run(2);
        pulse_cnt = 0;
        run(40);
        chk("R9 no pulse in lockup", pulse_cnt, 0);
        rst = 1'b1;
        run(3);
        chk("R1 reset clears wave", int'(wave), 0);
        start_s = 4'b0000; term_s = 4'b0101;
        run(1);
        rst = 1'b0;
        tag = "R5 after reset";
        run(13 * 4);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule